// File: doc/BRIEF.md
# Sixty-Four Line Interrupt Aggregator

The block gathers 64 level-sensitive interrupt lines and turns them into two request outputs for a processor: a normal request and a fast request. For every line it keeps a pending bit, an enable bit and a type bit that routes the line to one of the two outputs. A normal line also carries a 4-bit priority. The normal output is gated by a 5-bit threshold, so only sufficiently urgent work reaches the processor.

Software reaches the state through a word-addressed register bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data. Enables can be changed all at once through two 32-bit halves, or one line at a time by writing the line number. A force path overwrites the pending bits directly, which is useful for software-raised interrupts and for clearing stale requests. Choosing the winning vector is the job of a separate arbiter and is not done here. The two vector offsets are left for that arbiter.

Top module: `irq_hub`

## Requirements
- R1: After reset the threshold reads 31, and the control, enable, type, pending and priority registers read 0. Both request outputs are low.
- R2: A write to offset 2 sets the enable bit whose number is in write data bits [5:0]. A write to offset 3 clears that bit. Other data bits are ignored, and both offsets read 0.
- R3: The fast output is high exactly when some line is pending, enabled and of fast type (type bit 1). It follows its inputs with a one-cycle register delay.
- R4: The normal output looks at lines that are pending, enabled and of normal type (type bit 0). It is high when any of them has a priority strictly greater than the threshold. Thresholds 16 to 30 therefore block every normal line.
- R5: With a threshold of 31, the normal output is high whenever any normal line is pending and enabled, whatever its priority.
- R6: The threshold at offset 1 keeps only write data bits [4:0].
- R7: The control word at offset 0 keeps only write bits 24, 22, 21, 20, 19 and 18. Every other bit, bit 25 included, reads 0.
- R8: A write to offset 20 replaces pending bits [63:32] and a write to offset 21 replaces bits [31:0]. Both offsets read 0.
- R9: The following registers are read-only, and writes to them leave all state unchanged:
  - raw pending at offsets 18/19 (high/low);
  - normal pending at offsets 22/23 (pending AND enable AND NOT type);
  - fast pending at offsets 24/25 (pending AND enable AND type).
- R10: A line whose level differs from its level one cycle earlier copies that level into its pending bit at the next clock edge. A line that holds its level leaves its pending bit alone. If a force write and a line change hit the same bit in the same cycle, the line level wins.
- R11: Enable is at offsets 4/5 and type at offsets 6/7, with the high half at the even offset. Priorities are at offsets 8 to 15. Offset 15 holds lines 0 to 7 and offset 8 holds lines 56 to 63, and line s uses bits [4*(s%8)+3 : 4*(s%8)].
- R12: Offsets 16, 17 and 26 to 63 read 0, and writes to them change nothing.
- R13: Read data appears on the read port in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_lines | input | 64 | Level-sensitive interrupt lines |
| nirq_out | output | 1 | Normal request |
| firq_out | output | 1 | Fast request |

## Verification
Two things can change the same pending bit in one cycle: a level change on a line, and a software force write to that bit's half. The bench drives both on the same falling edge. It uses one line that rises and another that falls, under force data with the opposite value for both. It then reads the raw pending word back and expects the line levels on the changed bits and the force data on the rest. The threshold gate is swept exhaustively over all 32 thresholds and all 16 priorities.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int OFS_CTRL     = 0;
  localparam int OFS_LEVEL    = 1;
  localparam int OFS_EN_NUM   = 2;
  localparam int OFS_DIS_NUM  = 3;
  localparam int OFS_EN_HI    = 4;
  localparam int OFS_EN_LO    = 5;
  localparam int OFS_TYP_HI   = 6;
  localparam int OFS_TYP_LO   = 7;
  localparam int OFS_PRI_BASE = 8;
  localparam int OFS_RAW_HI   = 18;
  localparam int OFS_RAW_LO   = 19;
  localparam int OFS_FRC_HI   = 20;
  localparam int OFS_FRC_LO   = 21;
  localparam int OFS_NPND_HI  = 22;
  localparam int OFS_NPND_LO  = 23;
  localparam int OFS_FPND_HI  = 24;
  localparam int OFS_FPND_LO  = 25;
  localparam int OFS_LAST     = 25;

  localparam logic [31:0] CTRL_KEEP = 32'h017C_0000;
endpackage

// File: rtl/irq_hub_cfg.sv
module irq_hub_cfg
  import irq_hub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4,
  parameter int LVL_W  = 5,
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           ctrl_q,
  output logic [LVL_W-1:0]            lvl_q,
  output logic [2*DATA_W-1:0]         en_q,
  output logic [2*DATA_W-1:0]         typ_q,
  output logic [(2*DATA_W/(DATA_W/PRIO_W))-1:0][DATA_W-1:0] pri_q
);
  localparam int SRC_N    = 2 * DATA_W;
  localparam int SEL_W    = $clog2(SRC_N);
  localparam int PPW      = DATA_W / PRIO_W;
  localparam int PWORDS   = SRC_N / PPW;
  localparam int PW_SEL   = (PWORDS > 1) ? $clog2(PWORDS) : 1;
  localparam int PRI_LAST = OFS_PRI_BASE + PWORDS - 1;

  logic [SEL_W-1:0]  num;
  logic              in_pri;
  logic [ADDR_W-1:0] pdiff;
  logic [PW_SEL-1:0] psel;

  assign num    = wdata[SEL_W-1:0];
  assign in_pri = (addr >= ADDR_W'(OFS_PRI_BASE)) && (addr <= ADDR_W'(PRI_LAST));
  assign pdiff  = ADDR_W'(PRI_LAST) - addr;
  assign psel   = pdiff[PW_SEL-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      lvl_q  <= '1;
    end else if (wr && addr == ADDR_W'(OFS_CTRL)) begin
      ctrl_q <= wdata & CTRL_KEEP[DATA_W-1:0];
    end else if (wr && addr == ADDR_W'(OFS_LEVEL)) begin
      lvl_q <= wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(OFS_EN_NUM))       en_q[num] <= 1'b1;
      else if (addr == ADDR_W'(OFS_DIS_NUM)) en_q[num] <= 1'b0;
      else if (addr == ADDR_W'(OFS_EN_HI))   en_q[SRC_N-1:DATA_W] <= wdata;
      else if (addr == ADDR_W'(OFS_EN_LO))   en_q[DATA_W-1:0] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      typ_q <= '0;
    end else if (wr && addr == ADDR_W'(OFS_TYP_HI)) begin
      typ_q[SRC_N-1:DATA_W] <= wdata;
    end else if (wr && addr == ADDR_W'(OFS_TYP_LO)) begin
      typ_q[DATA_W-1:0] <= wdata;
    end
  end

  generate
    for (genvar w = 0; w < PWORDS; w++) begin : g_pri
      always_ff @(posedge clk) begin
        if (rst) pri_q[w] <= '0;
        else if (wr && in_pri && psel == PW_SEL'(w)) pri_q[w] <= wdata;
      end
    end
  endgenerate

  AST_EN_NUM_SET: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_W'(OFS_EN_NUM)) |=> en_q[$past(num)]); // R2
  AST_EN_NUM_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_W'(OFS_DIS_NUM)) |=> !en_q[$past(num)]); // R2
  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == ADDR_W'(OFS_LEVEL)) |=> $stable(lvl_q)); // R6
endmodule

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*DATA_W-1:0] src,
  input  logic                frc_hi,
  input  logic                frc_lo,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] pend_q
);
  localparam int SRC_N = 2 * DATA_W;

  logic [SRC_N-1:0] src_q;
  logic [SRC_N-1:0] delta;
  logic [SRC_N-1:0] base;
  logic [SRC_N-1:0] pend_d;

  assign delta = src ^ src_q;

  always_comb begin
    base = pend_q;
    if (frc_hi) base[SRC_N-1:DATA_W] = wdata;
    if (frc_lo) base[DATA_W-1:0]     = wdata;
    pend_d = (base & ~delta) | (src & delta);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src;
      pend_q <= pend_d;
    end
  end

  AST_LINE_EDGE_COPY: assert property (@(posedge clk) disable iff (rst)
    (src != src_q) |=> ((pend_q & $past(delta)) == ($past(src) & $past(delta)))); // R10
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src == src_q && !frc_hi && !frc_lo) |=> $stable(pend_q)); // R10
endmodule

// File: rtl/irq_hub_gate.sv
module irq_hub_gate #(
  parameter int SRC_N  = 64,
  parameter int PRIO_W = 4,
  parameter int LVL_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SRC_N-1:0]        pend,
  input  logic [SRC_N-1:0]        en,
  input  logic [SRC_N-1:0]        typ,
  input  logic [SRC_N*PRIO_W-1:0] pri_flat,
  input  logic [LVL_W-1:0]        lvl,
  output logic                    nirq_q,
  output logic                    firq_q
);
  localparam int PRI_MAX = (1 << PRIO_W) - 1;

  logic [SRC_N-1:0] nrm;
  logic [SRC_N-1:0] fst;
  logic [SRC_N-1:0] hit;
  logic             open_lvl;

  assign nrm      = pend & en & ~typ;
  assign fst      = pend & en & typ;
  assign open_lvl = &lvl;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_cmp
      assign hit[i] = nrm[i] && (LVL_W'(pri_flat[i*PRIO_W +: PRIO_W]) > lvl);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      nirq_q <= 1'b0;
      firq_q <= 1'b0;
    end else begin
      nirq_q <= open_lvl ? (|nrm) : (|hit);
      firq_q <= |fst;
    end
  end

  AST_FIRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fst == '0) |=> !firq_q); // R3
  AST_LVL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (lvl > LVL_W'(PRI_MAX) && !open_lvl) |=> !nirq_q); // R4
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (rst)
    (open_lvl && nrm != '0) |=> nirq_q); // R5
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4,
  parameter int LVL_W  = 5,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [2*DATA_W-1:0] src_lines,
  output logic                nirq_out,
  output logic                firq_out
);
  localparam int SRC_N    = 2 * DATA_W;
  localparam int PPW      = DATA_W / PRIO_W;
  localparam int PWORDS   = SRC_N / PPW;
  localparam int PW_SEL   = (PWORDS > 1) ? $clog2(PWORDS) : 1;
  localparam int PRI_LAST = OFS_PRI_BASE + PWORDS - 1;

  logic [DATA_W-1:0]              ctrl_q;
  logic [LVL_W-1:0]               lvl_q;
  logic [SRC_N-1:0]               en_q;
  logic [SRC_N-1:0]               typ_q;
  logic [PWORDS-1:0][DATA_W-1:0]  pri_q;
  logic [SRC_N-1:0]               pend_q;
  logic [SRC_N-1:0]               npnd;
  logic [SRC_N-1:0]               fpnd;
  logic                           frc_hi;
  logic                           frc_lo;
  logic [DATA_W-1:0]              rd_d;
  logic [ADDR_W-1:0]              pdiff;
  logic [PW_SEL-1:0]              psel;

  assign frc_hi = bus_wr && bus_addr == ADDR_W'(OFS_FRC_HI);
  assign frc_lo = bus_wr && bus_addr == ADDR_W'(OFS_FRC_LO);
  assign npnd   = pend_q & en_q & ~typ_q;
  assign fpnd   = pend_q & en_q & typ_q;
  assign pdiff  = ADDR_W'(PRI_LAST) - bus_addr;
  assign psel   = pdiff[PW_SEL-1:0];

  irq_hub_cfg #(
    .DATA_W(DATA_W), .PRIO_W(PRIO_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .lvl_q(lvl_q), .en_q(en_q), .typ_q(typ_q), .pri_q(pri_q)
  );

  irq_hub_pend #(.DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst(rst), .src(src_lines), .frc_hi(frc_hi), .frc_lo(frc_lo),
    .wdata(bus_wdata), .pend_q(pend_q)
  );

  irq_hub_gate #(.SRC_N(SRC_N), .PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_gate (
    .clk(clk), .rst(rst), .pend(pend_q), .en(en_q), .typ(typ_q),
    .pri_flat(pri_q), .lvl(lvl_q), .nirq_q(nirq_out), .firq_q(firq_out)
  );

  always_comb begin
    rd_d = '0;
    if (bus_addr >= ADDR_W'(OFS_PRI_BASE) && bus_addr <= ADDR_W'(PRI_LAST)) begin
      rd_d = pri_q[psel];
    end else begin
      case (int'(bus_addr))
        OFS_CTRL:    rd_d = ctrl_q;
        OFS_LEVEL:   rd_d = DATA_W'(lvl_q);
        OFS_EN_HI:   rd_d = en_q[SRC_N-1:DATA_W];
        OFS_EN_LO:   rd_d = en_q[DATA_W-1:0];
        OFS_TYP_HI:  rd_d = typ_q[SRC_N-1:DATA_W];
        OFS_TYP_LO:  rd_d = typ_q[DATA_W-1:0];
        OFS_RAW_HI:  rd_d = pend_q[SRC_N-1:DATA_W];
        OFS_RAW_LO:  rd_d = pend_q[DATA_W-1:0];
        OFS_NPND_HI: rd_d = npnd[SRC_N-1:DATA_W];
        OFS_NPND_LO: rd_d = npnd[DATA_W-1:0];
        OFS_FPND_HI: rd_d = fpnd[SRC_N-1:DATA_W];
        OFS_FPND_LO: rd_d = fpnd[DATA_W-1:0];
        default:     rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > ADDR_W'(OFS_LAST)) |=> (bus_rdata == '0)); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R13
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] src_lines = '0;
  logic        nirq_out;
  logic        firq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_lines(src_lines), .nirq_out(nirq_out), .firq_out(firq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd64(input int hi, output logic [63:0] d);
    logic [31:0] h, l;
    rd(hi, h);
    rd(hi + 1, l);
    d = {h, l};
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] q, exp_en, pat;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 nirq", nirq_out, 0);
    chk("R1 firq", firq_out, 0);
    rd(0, r);  chk("R1 ctrl", r, 0);
    rd(1, r);  chk("R1 R13 level", r, 31);
    rd64(4, q); chk("R1 enable", q, 0);
    rd64(6, q); chk("R1 type", q, 0);
    rd64(18, q); chk("R1 pending", q, 0);
    rd(15, r); chk("R1 prio", r, 0);

    // R6 threshold width
    wr(1, 32'hFFFF_FFE5); rd(1, r); chk("R6 level", r, 5);

    // R7 control
    wr(0, 32'hFFFF_FFFF); rd(0, r); chk("R7 ctrl all", r, 32'h017C_0000);
    wr(0, 32'h0200_0000); rd(0, r); chk("R7 ctrl b25", r, 0);

    // R2 enable/disable by number, full sweep
    exp_en = '0;
    for (int n = 0; n < 64; n++) begin
      wr(2, 32'hFFFF_FFC0 | n);
      exp_en[n] = 1'b1;
      rd64(4, q); chk("R2 set", q, exp_en);
    end
    for (int n = 63; n >= 0; n -= 3) begin
      wr(3, 32'h5555_5540 | n);
      exp_en[n] = 1'b0;
      rd64(4, q); chk("R2 clr", q, exp_en);
    end
    rd(2, r); chk("R2 rd num en", r, 0);
    rd(3, r); chk("R2 rd num dis", r, 0);

    // R11 halves
    wr(4, 32'hA5A5_0000); wr(5, 32'h0000_1234);
    rd64(4, q); chk("R11 enable", q, 64'hA5A5_0000_0000_1234);
    wr(6, 32'h0F0F_0001); wr(7, 32'h8000_0000);
    rd64(6, q); chk("R11 type", q, 64'h0F0F_0001_8000_0000);

    // R8 force
    wr(20, 32'hDEAD_BEEF); wr(21, 32'h0BAD_F00D);
    rd64(18, q); chk("R8 force", q, 64'hDEAD_BEEF_0BAD_F00D);
    rd(20, r); chk("R8 rd hi", r, 0);
    rd(21, r); chk("R8 rd lo", r, 0);

    // R9 derived views and read-only
    pat = 64'hDEAD_BEEF_0BAD_F00D;
    rd64(22, q); chk("R9 npend", q, pat & 64'hA5A5_0000_0000_1234 & ~64'h0F0F_0001_8000_0000);
    rd64(24, q); chk("R9 fpend", q, pat & 64'hA5A5_0000_0000_1234 & 64'h0F0F_0001_8000_0000);
    for (int a = 18; a <= 25; a++) if (a != 20 && a != 21) wr(a, 32'h1357_9BDF);
    rd64(18, q); chk("R9 ro pend", q, pat);
    rd64(4, q);  chk("R9 ro en", q, 64'hA5A5_0000_0000_1234);

    // R12 unmapped
    wr(16, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF); wr(40, 32'hFFFF_FFFF);
    rd(16, r); chk("R12 rd16", r, 0);
    rd(17, r); chk("R12 rd17", r, 0);
    rd(40, r); chk("R12 rd40", r, 0);
    rd64(18, q); chk("R12 pend kept", q, pat);
    rd(1, r); chk("R12 level kept", r, 5);

    // R3 fast sweep
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    exp_en = '0;
    for (int i = 0; i < 64; i++) exp_en[i] = (i % 3 != 0);
    wr(4, exp_en[63:32]); wr(5, exp_en[31:0]);
    for (int i = 0; i < 64; i++) begin
      pat = 64'd1 << i;
      wr(20, pat[63:32]); wr(21, pat[31:0]);
      @(negedge clk);
      chk("R3 firq", firq_out, exp_en[i]);
      chk("R3 nirq quiet", nirq_out, 0);
    end

    // R4/R5 exhaustive threshold x priority on line 5
    wr(6, 0); wr(7, 0); wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    wr(20, 0); wr(21, 32'h0000_0020);
    for (int p = 0; p < 16; p++) begin
      wr(15, 32'(p) << 20);
      for (int m = 0; m < 32; m++) begin
        wr(1, 32'(m));
        @(negedge clk);
        chk((m == 31) ? "R5 open" : "R4 gate", nirq_out, (m == 31) || (p > m));
        chk("R4 firq quiet", firq_out, 0);
      end
    end
    wr(21, 0); @(negedge clk);
    chk("R5 open none", nirq_out, 0);

    // R11 priority word order: line 61 sits in offset 8 bits [23:20]
    wr(20, 32'h2000_0000); wr(1, 3); wr(15, 32'hFFFF_FFFF);
    wr(8, 32'h0090_0000); @(negedge clk);
    chk("R11 prio hi", nirq_out, 1);
    wr(8, 32'h0020_0000); @(negedge clk);
    chk("R11 prio low", nirq_out, 0);
    rd(8, r); chk("R11 prio rd", r, 32'h0020_0000);

    // R10 line changes
    wr(20, 0); wr(21, 0); wr(1, 31); @(negedge clk);
    src_lines[7] = 1'b1;
    @(negedge clk);
    chk("R10 out lag", nirq_out, 0);
    @(negedge clk);
    chk("R10 nirq up", nirq_out, 1);
    wr(21, 0);
    rd64(18, q); chk("R10 level held", q, 0);
    // same-cycle force and line change
    @(negedge clk);
    src_lines[2] = 1'b1; src_lines[7] = 1'b0;
    bus_addr = 6'd21; bus_wdata = 32'h0000_0F80; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd64(18, q); chk("R10 race", q, 64'h0000_0000_0000_0F04);
    src_lines[40] = 1'b1;
    @(negedge clk);
    src_lines[40] = 1'b0;
    @(negedge clk);
    rd64(18, q); chk("R10 fall", q, 64'h0000_0000_0000_0F04);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule